// File: doc/BRIEF.md
# Dual-Clock FIFO With Programmable Thresholds

This block is a 9-bit first-in first-out buffer with separate write and read clocks. Data enters on the write clock when both write enables are high, and leaves on the read clock when both read enables are high. The output data register changes only on a read-clock edge that performs a read. Each clock domain tracks the other side's pointer through a Gray-coded synchronizer chain. Each domain also owns registered status flags, all active low: empty and almost-empty on the read clock, full and almost-full on the write clock.

Two 18-bit threshold registers set the almost-empty and almost-full levels. Each is held as a low and a high 9-bit part. The level of the second write enable while reset is asserted selects the role of that pin. High picks normal mode, where the pin is the second write enable. Low picks load mode, where the pin becomes a load strobe. In load mode the strobe steers write-clock edges into the threshold registers. It also steers read-clock edges into a readback of those registers, one part per edge in a fixed rotating order. Both thresholds are 7 after reset.

Top module: `pflag_fifo`

## Requirements
- R1: While reset is high and after it is released: `empty_n` = 0, `full_n` = 1, `almost_empty_n` = 0, `almost_full_n` = 1, both thresholds = 7, and `rd_data` = 0.
- R2: `full_n` is driven low on the write clock once DEPTH words are stored. While it is low no write is accepted, whatever the enables are, and the stored contents stay unchanged.
- R3: `empty_n` is driven low on the read clock when no word is stored. While it is low no read is performed, whatever the enables are, and `rd_data` holds its value.
- R4: In normal mode a write happens only on a write-clock edge with `wr_en1` = 1 and `wr_en2_ld` = 1. With only one of them high, nothing is stored.
- R5: A read happens only on a read-clock edge with `rd_en1` = 1 and `rd_en2` = 1. It puts the oldest stored word on `rd_data` after that edge, in write order. A read-clock edge without a read leaves `rd_data` unchanged.
- R6: With `out_en` = 0, `rd_data` is driven all zero. Raising `out_en` again shows the held output register unchanged.
- R7: `almost_empty_n` is low when the stored count is at or below the 18-bit almost-empty threshold. `almost_full_n` is low when the free space (DEPTH minus count) is at or below the 18-bit almost-full threshold.
- R8: `wr_en2_ld` low during reset selects load mode. In load mode, a write-clock edge with `wr_en1` = 1 and `wr_en2_ld` = 1 stores `wr_data` into the next threshold part. The parts are taken in the order almost-empty low (threshold bits 8:0), almost-empty high (bits 17:9), almost-full low, almost-full high, then back to the first.
- R9: In load mode, a read-clock edge with `rd_en1` = 1, `rd_en2` = 1 and `wr_en2_ld` = 1 puts the next threshold part on `rd_data` in the same rotating order, starting from almost-empty low after reset. It leaves the FIFO contents and read order untouched.
- R10: In load mode, a FIFO write needs `wr_en1` = 1 with `wr_en2_ld` = 0. A FIFO read needs both read enables high with `wr_en2_ld` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock |
| rst | input | 1 | Synchronous active-high reset, seen by both clock domains |
| wr_en1 | input | 1 | First write enable |
| wr_en2_ld | input | 1 | Second write enable, or load strobe in load mode; its level during reset picks the mode |
| wr_data | input | 9 | Write data or threshold part |
| rd_clk | input | 1 | Read clock |
| rd_en1 | input | 1 | First read enable |
| rd_en2 | input | 1 | Second read enable |
| out_en | input | 1 | Output enable for the read data bus |
| rd_data | output | 9 | Read data or threshold readback |
| empty_n | output | 1 | Active-low empty flag (read clock) |
| full_n | output | 1 | Active-low full flag (write clock) |
| almost_empty_n | output | 1 | Active-low almost-empty flag (read clock) |
| almost_full_n | output | 1 | Active-low almost-full flag (write clock) |

## Verification
The bench builds the block with DEPTH = 64 and two synchronizer stages, using unrelated write and read clock periods. A depth of 64 puts the full boundary and the blocked writes beyond it within a few dozen writes. Both flag thresholds are checked at their default of 7 and at loaded values of 3 and 5. The short rotating load sequence lets the bench observe the wrap of both the load order and the readback order.

// File: rtl/pflag_fifo_pkg.sv
package pflag_fifo_pkg;

    localparam int WORD_W  = 9;
    localparam int PTR_MAX = 14;
    localparam int THR_W   = 2 * WORD_W;

    typedef logic [WORD_W-1:0]  word_t;
    typedef logic [PTR_MAX-1:0] ptr_t;
    typedef logic [THR_W-1:0]   thr_t;

    typedef enum logic {
        MODE_NORM = 1'b0,
        MODE_LOAD = 1'b1
    } mode_e;

    // Rotation order of the threshold parts; the sequence is behaviour.
    typedef enum logic [1:0] {
        SEL_AE_LO = 2'd0,
        SEL_AE_HI = 2'd1,
        SEL_AF_LO = 2'd2,
        SEL_AF_HI = 2'd3
    } osel_e;

    typedef struct packed {
        word_t af_hi;
        word_t af_lo;
        word_t ae_hi;
        word_t ae_lo;
    } offs_t;

    localparam word_t OFS_DEFAULT = word_t'(7);
    localparam offs_t OFFS_RESET  = '{af_hi: '0, af_lo: OFS_DEFAULT,
                                      ae_hi: '0, ae_lo: OFS_DEFAULT};

    function automatic osel_e sel_next(osel_e s);
        return osel_e'(s + 2'd1);
    endfunction

    function automatic word_t offs_get(offs_t o, osel_e s);
        word_t v;
        case (s)
            SEL_AE_LO: v = o.ae_lo;
            SEL_AE_HI: v = o.ae_hi;
            SEL_AF_LO: v = o.af_lo;
            default:   v = o.af_hi;
        endcase
        return v;
    endfunction

    function automatic offs_t offs_put(offs_t o, osel_e s, word_t v);
        offs_t r;
        r = o;
        case (s)
            SEL_AE_LO: r.ae_lo = v;
            SEL_AE_HI: r.ae_hi = v;
            SEL_AF_LO: r.af_lo = v;
            default:   r.af_hi = v;
        endcase
        return r;
    endfunction

    function automatic thr_t ae_thr(offs_t o);
        return {o.ae_hi, o.ae_lo};
    endfunction

    function automatic thr_t af_thr(offs_t o);
        return {o.af_hi, o.af_lo};
    endfunction

    function automatic ptr_t bin2gray(ptr_t b);
        return b ^ (b >> 1);
    endfunction

    function automatic ptr_t gray2bin(ptr_t g);
        ptr_t r;
        r[PTR_MAX-1] = g[PTR_MAX-1];
        for (int i = PTR_MAX - 2; i >= 0; i--) begin
            r[i] = r[i+1] ^ g[i];
        end
        return r;
    endfunction

endpackage

// File: rtl/pflag_sync.sv
module pflag_sync #(
    parameter int W      = 7,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [STAGES-1:0][W-1:0] stg;

    always_ff @(posedge clk) begin
        if (rst) begin
            stg <= '0;
        end else begin
            stg <= {stg[STAGES-2:0], d};
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/pflag_ram.sv
module pflag_ram
    import pflag_fifo_pkg::*;
#(
    parameter  int DEPTH = 64,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  word_t         wdata,
    input  logic [AW-1:0] raddr,
    output word_t         rdata
);

    word_t mem [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/pflag_wr_side.sv
module pflag_wr_side
    import pflag_fifo_pkg::*;
#(
    parameter  int DEPTH = 64,
    localparam int AW    = $clog2(DEPTH),
    localparam int PW    = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en1,
    input  logic          en2_ld,
    input  word_t         din,
    input  logic [PW-1:0] rgray_s,
    output logic [PW-1:0] wgray,
    output logic          mem_we,
    output logic [AW-1:0] mem_waddr,
    output offs_t         offs,
    output logic          full_n,
    output logic          afull_n
);

    localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);

    mode_e         mode_q;
    osel_e         sel_q;
    offs_t         offs_q;
    logic [PW-1:0] wbin_q, wbin_nx, rbin_s, cnt_cur, cnt_nx, free_nx;
    logic          wr_try, wr_go, ld_go;
    logic          full_n_q, afull_n_q, full_nx, afull_nx;

    // Role of the dual-purpose pin is captured while reset is held.
    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= en2_ld ? MODE_NORM : MODE_LOAD;
        end
    end

    always_comb begin
        rbin_s   = PW'(gray2bin(ptr_t'(rgray_s)));
        wr_try   = (mode_q == MODE_LOAD) ? (en1 & ~en2_ld) : (en1 & en2_ld);
        ld_go    = (mode_q == MODE_LOAD) & en1 & en2_ld;
        wr_go    = wr_try & full_n_q;
        wbin_nx  = wbin_q + PW'(wr_go);
        cnt_cur  = wbin_q - rbin_s;
        cnt_nx   = wbin_nx - rbin_s;
        free_nx  = DEPTH_P - cnt_nx;
        full_nx  = (cnt_nx != DEPTH_P);
        afull_nx = (thr_t'(free_nx) > af_thr(offs_q));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wbin_q    <= '0;
            wgray     <= '0;
            full_n_q  <= 1'b1;
            afull_n_q <= 1'b1;
            sel_q     <= SEL_AE_LO;
            offs_q    <= OFFS_RESET;
        end else begin
            wbin_q    <= wbin_nx;
            wgray     <= PW'(bin2gray(ptr_t'(wbin_nx)));
            full_n_q  <= full_nx;
            afull_n_q <= afull_nx;
            if (ld_go) begin
                offs_q <= offs_put(offs_q, sel_q, din);
                sel_q  <= sel_next(sel_q);
            end
        end
    end

    assign mem_we    = wr_go;
    assign mem_waddr = wbin_q[AW-1:0];
    assign offs      = offs_q;
    assign full_n    = full_n_q;
    assign afull_n   = afull_n_q;

    // R2: a blocked write leaves the write pointer where it was
    p_full_blocks_r2: assert property (@(posedge clk) disable iff (rst)
        (!full_n_q && wr_try) |=> (wbin_q == $past(wbin_q)));

    // R2: stored count never exceeds the depth
    p_count_cap_r2: assert property (@(posedge clk) disable iff (rst)
        cnt_cur <= DEPTH_P);

    // R2: the pointer sent across the clock boundary moves one bit at a time
    p_wgray_step_r2: assert property (@(posedge clk) disable iff (rst)
        $countones(wgray ^ $past(wgray)) <= 1);

    // R8: each load moves on to the next threshold part
    p_load_order_r8: assert property (@(posedge clk) disable iff (rst)
        ld_go |=> (sel_q == sel_next($past(sel_q))));

    // R8: a threshold load stores nothing in the FIFO
    p_load_no_push_r8: assert property (@(posedge clk) disable iff (rst)
        ld_go |=> $stable(wbin_q));

endmodule

// File: rtl/pflag_rd_side.sv
module pflag_rd_side
    import pflag_fifo_pkg::*;
#(
    parameter  int DEPTH = 64,
    localparam int AW    = $clog2(DEPTH),
    localparam int PW    = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en1,
    input  logic          en2,
    input  logic          ld_pin,
    input  logic          out_en,
    input  logic [PW-1:0] wgray_s,
    input  offs_t         offs,
    input  word_t         mem_rdata,
    output logic [AW-1:0] mem_raddr,
    output logic [PW-1:0] rgray,
    output word_t         dout,
    output logic          empty_n,
    output logic          aempty_n
);

    mode_e         mode_q;
    osel_e         rsel_q;
    word_t         dout_q;
    logic [PW-1:0] rbin_q, rbin_nx, wbin_s, cnt_nx;
    logic          rb_go, rd_try, rd_go;
    logic          empty_n_q, aempty_n_q, empty_nx, aempty_nx;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= ld_pin ? MODE_NORM : MODE_LOAD;
        end
    end

    always_comb begin
        wbin_s    = PW'(gray2bin(ptr_t'(wgray_s)));
        rb_go     = (mode_q == MODE_LOAD) & en1 & en2 & ld_pin;
        rd_try    = en1 & en2 & ~rb_go;
        rd_go     = rd_try & empty_n_q;
        rbin_nx   = rbin_q + PW'(rd_go);
        cnt_nx    = wbin_s - rbin_nx;
        empty_nx  = (cnt_nx != '0);
        aempty_nx = (thr_t'(cnt_nx) > ae_thr(offs));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rbin_q     <= '0;
            rgray      <= '0;
            empty_n_q  <= 1'b0;
            aempty_n_q <= 1'b0;
            rsel_q     <= SEL_AE_LO;
            dout_q     <= '0;
        end else begin
            rbin_q     <= rbin_nx;
            rgray      <= PW'(bin2gray(ptr_t'(rbin_nx)));
            empty_n_q  <= empty_nx;
            aempty_n_q <= aempty_nx;
            if (rd_go) begin
                dout_q <= mem_rdata;
            end else if (rb_go) begin
                dout_q <= offs_get(offs, rsel_q);
            end
            if (rb_go) begin
                rsel_q <= sel_next(rsel_q);
            end
        end
    end

    assign mem_raddr = rbin_q[AW-1:0];
    assign dout      = out_en ? dout_q : '0;
    assign empty_n   = empty_n_q;
    assign aempty_n  = aempty_n_q;

    // R3: a read attempted while empty changes neither pointer nor output
    p_empty_blocks_r3: assert property (@(posedge clk) disable iff (rst)
        (!empty_n_q && rd_try) |=> ($stable(rbin_q) && $stable(dout_q)));

    // R5: the output register holds on edges with no read and no readback
    p_dout_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !(rd_go || rb_go) |=> $stable(dout_q));

    // R9: readback never moves the read pointer
    p_rb_keeps_ptr_r9: assert property (@(posedge clk) disable iff (rst)
        rb_go |=> $stable(rbin_q));

    // R9: readback walks the parts in the rotating order
    p_rb_order_r9: assert property (@(posedge clk) disable iff (rst)
        rb_go |=> (rsel_q == sel_next($past(rsel_q))));

    // R3: the read pointer sent across moves one bit at a time
    p_rgray_step_r3: assert property (@(posedge clk) disable iff (rst)
        $countones(rgray ^ $past(rgray)) <= 1);

endmodule

// File: rtl/pflag_fifo.sv
module pflag_fifo
    import pflag_fifo_pkg::*;
#(
    parameter  int DEPTH       = 64,
    parameter  int SYNC_STAGES = 2,
    localparam int AW          = $clog2(DEPTH),
    localparam int PW          = AW + 1
) (
    input  logic        wr_clk,
    input  logic        rst,
    input  logic        wr_en1,
    input  logic        wr_en2_ld,
    input  logic [8:0]  wr_data,
    input  logic        rd_clk,
    input  logic        rd_en1,
    input  logic        rd_en2,
    input  logic        out_en,
    output logic [8:0]  rd_data,
    output logic        empty_n,
    output logic        full_n,
    output logic        almost_empty_n,
    output logic        almost_full_n
);

    logic [PW-1:0] wgray, rgray, wgray_s, rgray_s;
    logic [AW-1:0] waddr, raddr;
    logic          mem_we;
    word_t         mem_rdata;
    offs_t         offs;

    pflag_wr_side #(.DEPTH(DEPTH)) u_wr (
        .clk       (wr_clk),
        .rst       (rst),
        .en1       (wr_en1),
        .en2_ld    (wr_en2_ld),
        .din       (wr_data),
        .rgray_s   (rgray_s),
        .wgray     (wgray),
        .mem_we    (mem_we),
        .mem_waddr (waddr),
        .offs      (offs),
        .full_n    (full_n),
        .afull_n   (almost_full_n)
    );

    pflag_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_sync_r2w (
        .clk (wr_clk),
        .rst (rst),
        .d   (rgray),
        .q   (rgray_s)
    );

    pflag_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_sync_w2r (
        .clk (rd_clk),
        .rst (rst),
        .d   (wgray),
        .q   (wgray_s)
    );

    pflag_ram #(.DEPTH(DEPTH)) u_ram (
        .wclk  (wr_clk),
        .we    (mem_we),
        .waddr (waddr),
        .wdata (wr_data),
        .raddr (raddr),
        .rdata (mem_rdata)
    );

    pflag_rd_side #(.DEPTH(DEPTH)) u_rd (
        .clk       (rd_clk),
        .rst       (rst),
        .en1       (rd_en1),
        .en2       (rd_en2),
        .ld_pin    (wr_en2_ld),
        .out_en    (out_en),
        .wgray_s   (wgray_s),
        .offs      (offs),
        .mem_rdata (mem_rdata),
        .mem_raddr (raddr),
        .rgray     (rgray),
        .dout      (rd_data),
        .empty_n   (empty_n),
        .aempty_n  (almost_empty_n)
    );

endmodule

// File: tb/pflag_fifo_tb.sv
module pflag_fifo_tb;

    localparam int DEPTH = 64;

    logic       wr_clk = 1'b0;
    logic       rd_clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en1 = 1'b0;
    logic       wr_en2_ld = 1'b1;
    logic [8:0] wr_data = '0;
    logic       rd_en1 = 1'b0;
    logic       rd_en2 = 1'b0;
    logic       out_en = 1'b1;
    logic [8:0] rd_data;
    logic       empty_n, full_n, almost_empty_n, almost_full_n;

    int         n_chk = 0;
    int         n_bad = 0;
    bit         done = 1'b0;
    bit         ldm = 1'b0;
    int         ae_off = 7;
    int         af_off = 7;
    logic [8:0] mq[$];
    logic [8:0] last_dout = '0;

    always #10 wr_clk = ~wr_clk;
    always #7  rd_clk = ~rd_clk;

    pflag_fifo #(.DEPTH(DEPTH)) u_dut (
        .wr_clk         (wr_clk),
        .rst            (rst),
        .wr_en1         (wr_en1),
        .wr_en2_ld      (wr_en2_ld),
        .wr_data        (wr_data),
        .rd_clk         (rd_clk),
        .rd_en1         (rd_en1),
        .rd_en2         (rd_en2),
        .out_en         (out_en),
        .rd_data        (rd_data),
        .empty_n        (empty_n),
        .full_n         (full_n),
        .almost_empty_n (almost_empty_n),
        .almost_full_n  (almost_full_n)
    );

    function automatic bit exp_ae_n(int cnt);
        return !(cnt <= ae_off);
    endfunction

    function automatic bit exp_af_n(int cnt);
        return !((DEPTH - cnt) <= af_off);
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic settle;
        repeat (6) @(posedge wr_clk);
        repeat (6) @(posedge rd_clk);
        #1;
    endtask

    task automatic flags(input string tag);
        int c;
        settle();
        c = mq.size();
        chk(empty_n == (c != 0), {tag, " empty_n"}, int'(empty_n), int'(c != 0));
        chk(full_n == (c != DEPTH), {tag, " full_n"}, int'(full_n), int'(c != DEPTH));
        chk(almost_empty_n == exp_ae_n(c), {tag, " almost_empty_n"},
            int'(almost_empty_n), int'(exp_ae_n(c)));
        chk(almost_full_n == exp_af_n(c), {tag, " almost_full_n"},
            int'(almost_full_n), int'(exp_af_n(c)));
    endtask

    task automatic do_reset(input bit load_mode);
        @(negedge wr_clk);
        rst = 1'b1;
        ldm = load_mode;
        wr_en1 = 1'b0;
        wr_en2_ld = !load_mode;
        rd_en1 = 1'b0;
        rd_en2 = 1'b0;
        repeat (4) @(posedge wr_clk);
        repeat (3) @(posedge rd_clk);
        @(negedge wr_clk);
        rst = 1'b0;
        mq.delete();
        last_dout = '0;
        ae_off = 7;
        af_off = 7;
        settle();
    endtask

    task automatic push(input bit e1, input bit e2, input logic [8:0] d);
        bit fire;
        @(negedge wr_clk);
        wr_en1 = e1;
        wr_en2_ld = e2;
        wr_data = d;
        @(posedge wr_clk);
        #1;
        fire = ldm ? (e1 && !e2) : (e1 && e2);
        if (fire && mq.size() < DEPTH) mq.push_back(d);
        wr_en1 = 1'b0;
        wr_en2_ld = !ldm;
    endtask

    task automatic pull(input bit e1, input bit e2);
        string tag;
        @(negedge rd_clk);
        rd_en1 = e1;
        rd_en2 = e2;
        @(posedge rd_clk);
        #1;
        rd_en1 = 1'b0;
        rd_en2 = 1'b0;
        if (e1 && e2 && mq.size() > 0) begin
            last_dout = mq.pop_front();
            tag = "R5 read data in write order";
        end else if (e1 && e2) begin
            tag = "R3 read blocked while empty";
        end else begin
            tag = "R5 single read enable holds output";
        end
        chk(rd_data == last_dout, tag, int'(rd_data), int'(last_dout));
    endtask

    task automatic load_part(input logic [8:0] d);
        @(negedge wr_clk);
        wr_en1 = 1'b1;
        wr_en2_ld = 1'b1;
        wr_data = d;
        @(posedge wr_clk);
        #1;
        wr_en1 = 1'b0;
        wr_en2_ld = 1'b0;
    endtask

    task automatic read_part(input logic [8:0] exp, input string tag);
        @(negedge rd_clk);
        wr_en2_ld = 1'b1;
        rd_en1 = 1'b1;
        rd_en2 = 1'b1;
        @(posedge rd_clk);
        #1;
        rd_en1 = 1'b0;
        rd_en2 = 1'b0;
        wr_en2_ld = 1'b0;
        last_dout = exp;
        chk(rd_data == exp, tag, int'(rd_data), int'(exp));
    endtask

    task automatic drain;
        while (mq.size() > 0) pull(1'b1, 1'b1);
    endtask

    initial begin
        void'($urandom(32'd2718));

        // ---------------- normal mode ----------------
        @(posedge wr_clk);
        #1;
        chk(empty_n == 1'b0, "R1 empty_n during reset", int'(empty_n), 0);
        chk(full_n == 1'b1, "R1 full_n during reset", int'(full_n), 1);
        do_reset(1'b0);
        chk(empty_n == 1'b0, "R1 empty_n after reset", int'(empty_n), 0);
        chk(full_n == 1'b1, "R1 full_n after reset", int'(full_n), 1);
        chk(almost_empty_n == 1'b0, "R1 almost_empty_n after reset", int'(almost_empty_n), 0);
        chk(almost_full_n == 1'b1, "R1 almost_full_n after reset", int'(almost_full_n), 1);
        chk(rd_data == 9'd0, "R1 rd_data after reset", int'(rd_data), 0);

        // R4: one write enable alone stores nothing
        push(1'b1, 1'b0, 9'h0AA);
        push(1'b0, 1'b1, 9'h055);
        flags("R4 single write enable ignored");

        // R7: almost-empty boundary at the default threshold 7
        for (int i = 0; i < 7; i++) push(1'b1, 1'b1, 9'($urandom));
        flags("R7 count 7 at default threshold");
        push(1'b1, 1'b1, 9'($urandom));
        flags("R7 count 8 above default threshold");

        // R7: almost-full boundary (free 8 then free 7)
        while (mq.size() < DEPTH - 8) push(1'b1, 1'b1, 9'($urandom));
        flags("R7 free space 8");
        push(1'b1, 1'b1, 9'($urandom));
        flags("R7 free space 7");

        // R2: fill, then writes beyond full are refused
        while (mq.size() < DEPTH) push(1'b1, 1'b1, 9'($urandom));
        flags("R2 full");
        for (int i = 0; i < 3; i++) push(1'b1, 1'b1, 9'h1FF);
        flags("R2 writes blocked while full");

        // R5: drain with mixed enable patterns, order checked word by word
        while (mq.size() > 0) pull(($urandom % 4) != 0, ($urandom % 4) != 0);
        flags("R3 empty after drain");
        pull(1'b1, 1'b1);
        pull(1'b1, 1'b1);

        // R6: output enable
        @(negedge rd_clk);
        out_en = 1'b0;
        #1;
        chk(rd_data == 9'd0, "R6 bus zero when disabled", int'(rd_data), 0);
        out_en = 1'b1;
        #1;
        chk(rd_data == last_dout, "R6 held word shown again", int'(rd_data), int'(last_dout));

        // Random bursts
        for (int k = 0; k < 30; k++) begin
            int nw;
            int nr;
            nw = $urandom_range(0, 40);
            for (int i = 0; i < nw; i++)
                push(($urandom % 4) != 0, ($urandom % 4) != 0, 9'($urandom));
            flags("R2/R7 random writes");
            nr = $urandom_range(0, 40);
            for (int i = 0; i < nr; i++)
                pull(($urandom % 4) != 0, ($urandom % 4) != 0);
            flags("R3/R7 random reads");
        end
        drain();

        // ---------------- load mode ----------------
        do_reset(1'b1);
        flags("R1 load mode reset flags");
        // R10: FIFO writes take wr_en1 with the strobe low
        push(1'b1, 1'b0, 9'h101);
        push(1'b1, 1'b0, 9'h0C3);
        push(1'b0, 1'b0, 9'h1EE);
        flags("R10 load mode writes");

        // R8: five loads, the fifth wraps onto the first part
        load_part(9'h111);
        load_part(9'h000);
        load_part(9'h005);
        load_part(9'h000);
        load_part(9'h003);
        ae_off = 3;
        af_off = 5;
        flags("R8 loaded thresholds 3 and 5");

        // R9: readback order and wrap, FIFO untouched
        read_part(9'h003, "R9 readback part 0 (R8 wrap overwrote it)");
        read_part(9'h000, "R9 readback part 1");
        read_part(9'h005, "R9 readback part 2");
        read_part(9'h000, "R9 readback part 3");
        read_part(9'h003, "R9 readback wraps to part 0");
        flags("R9 contents kept after readback");

        push(1'b1, 1'b0, 9'h011);
        flags("R7 count 3 at loaded threshold");
        push(1'b1, 1'b0, 9'h022);
        flags("R7 count 4 above loaded threshold");
        pull(1'b1, 1'b1);
        chk(rd_data == 9'h101, "R9 first word after readback", int'(rd_data), 9'h101);
        pull(1'b1, 1'b1);
        pull(1'b1, 1'b1);
        pull(1'b1, 1'b1);
        flags("R10 load mode reads");

        while (mq.size() < DEPTH - 6) push(1'b1, 1'b0, 9'($urandom));
        flags("R7 free 6 with loaded threshold 5");
        push(1'b1, 1'b0, 9'($urandom));
        flags("R7 free 5 with loaded threshold 5");
        drain();
        flags("R3 empty after load mode drain");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #3_000_000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule